// File: doc/BRIEF.md
# Arithmetic Condition Code Generator

This block turns the outcome of an integer operation into a 2-bit condition code. It does no arithmetic itself. The caller presents a 5-bit operation selector and up to three operands, and the block classifies them: the first operand, the second operand and the result the datapath already computed. Odd selectors in the operation range work on the full 64-bit operands. Even selectors work on the low 32-bit halves and ignore the upper halves. The one exception is selector 28, which always works on 64 bits.

The operations fall into five kinds:

- signed and unsigned compares, and a signed test of the result against zero;
- signed add and subtract with overflow detection;
- logical (unsigned) add and subtract that fold carry or borrow and zero-ness into one code;
- absolute value, negative absolute value and complement classification;
- a nonzero test.

For the with-carry and with-borrow variants, the incoming carry or borrow is recovered from the three operands alone, so no separate flag input is needed. Selectors 0 to 3 return their own value. Selectors 29 to 31 are unassigned and raise an error flag.

The classification is captured in an output register on a valid strobe. The result appears one clock later, and the registered code holds until the next strobe. A parameter can remove the register for a purely combinational variant.

Top module: `cond_code_gen`

## Requirements
- R1: Selectors 0, 1, 2 and 3 produce a code equal to the selector value, whatever the operands.
- R2: Compare selectors 6/7 (signed) and 8/9 (unsigned) give 0 when op_a equals op_b, 1 when op_a is below op_b, and 2 when op_a is above op_b.
- R3: Test selectors 4/5 classify op_r as a signed value against zero: 0 for zero, 1 for negative, 2 for positive.
- R4: Signed add (10/11) and signed subtract (16/17) give 3 on overflow and otherwise classify op_r as 0 zero, 1 negative, 2 positive.
  - Add overflow is two positive operands with a negative result, or two negative operands with a positive result.
  - Subtract overflow is a positive op_a minus a negative op_b giving a negative result, or a negative minus a positive giving a positive result.
  - Zero counts as neither positive nor negative.
- R5: Logical add (12/13) gives the code bit 0 = result nonzero, bit 1 = carry-out, where carry-out is op_r unsigned-below op_a. Add-with-carry (14/15) uses the same code layout with a recovered carry.
  - First form x = op_r - op_a, wrapped to the operating width.
  - Carry-out is then x below op_b, or op_r below op_a.
- R6: Logical subtract (18/19) gives 2 for a zero result. For a nonzero result it gives 1 when op_b exceeds op_a, and 3 otherwise.
- R7: Subtract-with-borrow (20/21) detects a borrow-in when op_r differs from op_a - op_b wrapped to the operating width.
  - With a borrow-in, borrow-out is op_b >= op_a; without one, it is op_b > op_a.
  - The code is bit 0 = result nonzero, bit 1 = no borrow-out.
- R8: Absolute value (22/23) gives 3 for the most negative value (sign bit alone), 2 for any other nonzero value and 0 for zero. Negative absolute value (24/25) gives 1 for nonzero and 0 for zero. Complement (26/27) gives 3 for the most negative value, 1 for negative, 2 for positive and 0 for zero. All three classify op_r.
- R9: Selector 28 gives 1 when the full 64-bit op_r is nonzero and 0 otherwise.
- R10: Selectors 29, 30 and 31 set sel_err with a code of 0. Any assigned selector clears sel_err.
- R11: With the output register present, a strobe on in_valid updates cc and sel_err at the next rising clock edge and raises out_valid for exactly that one cycle. Without a strobe, cc and sel_err hold.
- R12: While rst_n is low, cc is 0, sel_err is 0 and out_valid is 0.
- R13: For even selectors from 4 to 26, bits 63..32 of all operands have no effect on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures a new classification |
| sel | input | 5 | Operation selector |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_r | input | 64 | Result operand |
| out_valid | output | 1 | High for the cycle after a strobe |
| cc | output | 2 | Registered condition code |
| sel_err | output | 1 | Unassigned selector seen at the last strobe |

## Verification
Every code, the error flag and out_valid are due on the single rising edge that follows the strobe. out_valid drops again on the edge after that.

The bench drives each stimulus just after a falling edge and removes the strobe one falling edge later. It reads the outputs at that same falling edge, halfway between the capturing edge and the next one. The same cadence is used to confirm that outputs hold through idle cycles in which the inputs change. Back-to-back strobes are sampled one falling edge apart, so each result is seen in its own cycle.

// File: rtl/cc_gen_pkg.sv
package cc_gen_pkg;

    typedef enum logic [4:0] {
        SEL_K0, SEL_K1, SEL_K2, SEL_K3,
        SEL_TST_N, SEL_TST_W,
        SEL_CMPS_N, SEL_CMPS_W,
        SEL_CMPU_N, SEL_CMPU_W,
        SEL_ADDS_N, SEL_ADDS_W,
        SEL_ADDL_N, SEL_ADDL_W,
        SEL_ADDC_N, SEL_ADDC_W,
        SEL_SUBS_N, SEL_SUBS_W,
        SEL_SUBL_N, SEL_SUBL_W,
        SEL_SUBB_N, SEL_SUBB_W,
        SEL_ABS_N, SEL_ABS_W,
        SEL_NABS_N, SEL_NABS_W,
        SEL_CPL_N, SEL_CPL_W,
        SEL_NZ
    } cc_sel_e;

    // Group boundaries used by the top-level result selector
    localparam logic [4:0] GRP_CMP_LO = 5'd4;
    localparam logic [4:0] GRP_ARI_LO = 5'd10;
    localparam logic [4:0] GRP_UNA_LO = 5'd22;
    localparam logic [4:0] SEL_TOP    = 5'd28;

    localparam int OPND_A = 0;
    localparam int OPND_B = 1;
    localparam int OPND_R = 2;

    // Zero / negative / positive -> 0 / 1 / 2
    function automatic logic [1:0] sign_class(input logic is_zero, input logic is_neg);
        if (is_zero) return 2'd0;
        if (is_neg)  return 2'd1;
        return 2'd2;
    endfunction

endpackage

// File: rtl/cc_opnd_fmt.sv
module cc_opnd_fmt #(
    parameter int DW = 64
) (
    input  logic                wide,
    input  logic [2:0][DW-1:0]  raw,
    output logic [2:0][DW-1:0]  sx,
    output logic [2:0][DW-1:0]  zx,
    output logic [2:0]          neg,
    output logic [2:0]          nz
);
    localparam int HW = DW / 2;

    // Same narrowing for each of the three operands
    for (genvar i = 0; i < 3; i++) begin : g_opnd
        assign sx[i]  = wide ? raw[i] : {{(DW-HW){raw[i][HW-1]}}, raw[i][HW-1:0]};
        assign zx[i]  = wide ? raw[i] : {{(DW-HW){1'b0}}, raw[i][HW-1:0]};
        assign neg[i] = sx[i][DW-1];
        assign nz[i]  = |zx[i];
    end
endmodule

// File: rtl/cc_cmp_unit.sv
module cc_cmp_unit
    import cc_gen_pkg::*;
#(
    parameter int DW = 64
) (
    input  cc_sel_e          sel,
    input  logic [DW-1:0]    a_sx,
    input  logic [DW-1:0]    b_sx,
    input  logic [DW-1:0]    a_zx,
    input  logic [DW-1:0]    b_zx,
    input  logic [DW-1:0]    r_sx,
    output logic [1:0]       cc
);
    logic s_lt, u_lt, eq;

    assign eq   = (a_zx == b_zx);
    assign s_lt = ($signed(a_sx) < $signed(b_sx));
    assign u_lt = (a_zx < b_zx);

    always_comb begin
        case (sel)
            SEL_TST_N, SEL_TST_W:   cc = sign_class(r_sx == '0, $signed(r_sx) < 0);
            SEL_CMPS_N, SEL_CMPS_W: cc = eq ? 2'd0 : (s_lt ? 2'd1 : 2'd2);
            SEL_CMPU_N, SEL_CMPU_W: cc = eq ? 2'd0 : (u_lt ? 2'd1 : 2'd2);
            default:                cc = 2'd0;
        endcase
    end
endmodule

// File: rtl/cc_arith_unit.sv
module cc_arith_unit
    import cc_gen_pkg::*;
#(
    parameter int DW = 64
) (
    input  cc_sel_e          sel,
    input  logic             wide,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [DW-1:0]    r,
    input  logic [2:0]       neg,
    input  logic [2:0]       nz,
    output logic [1:0]       cc
);
    localparam int            HW     = DW / 2;
    localparam logic [DW-1:0] LOMASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

    logic [DW-1:0] keep, b_plus_cin, plain_diff;
    logic          pos_a, pos_b, pos_r;
    logic          ovf_add, ovf_sub;
    logic          cy_plain, cy_rec, borrow_in, borrow_out;

    assign keep  = wide ? '1 : LOMASK;
    assign pos_a = !neg[OPND_A] && nz[OPND_A];
    assign pos_b = !neg[OPND_B] && nz[OPND_B];
    assign pos_r = !neg[OPND_R] && nz[OPND_R];

    assign ovf_add = (pos_a && pos_b && neg[OPND_R]) ||
                     (neg[OPND_A] && neg[OPND_B] && pos_r);
    assign ovf_sub = (pos_a && neg[OPND_B] && neg[OPND_R]) ||
                     (neg[OPND_A] && pos_b && pos_r);

    // Carry recovery: result minus first operand gives second plus carry-in
    assign b_plus_cin = (r - a) & keep;
    assign cy_plain   = (r < a);
    assign cy_rec     = (b_plus_cin < b) || (r < a);

    // Borrow recovery: a mismatch with the plain difference implies a borrow-in
    assign plain_diff = (a - b) & keep;
    assign borrow_in  = (r != plain_diff);
    assign borrow_out = borrow_in ? (b >= a) : (b > a);

    always_comb begin
        case (sel)
            SEL_ADDS_N, SEL_ADDS_W:
                cc = ovf_add ? 2'd3 : sign_class(!nz[OPND_R], neg[OPND_R]);
            SEL_SUBS_N, SEL_SUBS_W:
                cc = ovf_sub ? 2'd3 : sign_class(!nz[OPND_R], neg[OPND_R]);
            SEL_ADDL_N, SEL_ADDL_W: cc = {cy_plain, nz[OPND_R]};
            SEL_ADDC_N, SEL_ADDC_W: cc = {cy_rec, nz[OPND_R]};
            SEL_SUBL_N, SEL_SUBL_W:
                cc = !nz[OPND_R] ? 2'd2 : ((b > a) ? 2'd1 : 2'd3);
            SEL_SUBB_N, SEL_SUBB_W: cc = {!borrow_out, nz[OPND_R]};
            default:                cc = 2'd0;
        endcase
    end
endmodule

// File: rtl/cc_unary_unit.sv
module cc_unary_unit
    import cc_gen_pkg::*;
#(
    parameter int DW = 64
) (
    input  cc_sel_e          sel,
    input  logic             wide,
    input  logic [DW-1:0]    r,
    input  logic             r_neg,
    input  logic             r_nz,
    output logic [1:0]       cc
);
    localparam int            HW    = DW / 2;
    localparam logic [DW-1:0] MIN_W = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MIN_N = {{(DW-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};

    logic is_min;

    assign is_min = (r == (wide ? MIN_W : MIN_N));

    always_comb begin
        case (sel)
            SEL_ABS_N, SEL_ABS_W:   cc = is_min ? 2'd3 : (r_nz ? 2'd2 : 2'd0);
            SEL_NABS_N, SEL_NABS_W: cc = {1'b0, r_nz};
            SEL_CPL_N, SEL_CPL_W:   cc = is_min ? 2'd3 : sign_class(!r_nz, r_neg);
            SEL_NZ:                 cc = {1'b0, r_nz};
            default:                cc = 2'd0;
        endcase
    end
endmodule

// File: rtl/cond_code_gen.sv
module cond_code_gen
    import cc_gen_pkg::*;
#(
    parameter int DW      = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [4:0]     sel,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    input  logic [DW-1:0]  op_r,
    output logic           out_valid,
    output logic [1:0]     cc,
    output logic           sel_err
);
    cc_sel_e           sel_e;
    logic              wide;
    logic [2:0][DW-1:0] opnd_sx, opnd_zx;
    logic [2:0]        opnd_neg, opnd_nz;
    logic [1:0]        cmp_cc, ari_cc, una_cc;
    logic [1:0]        cc_nx;
    logic              err_nx;

    assign sel_e = cc_sel_e'(sel);
    assign wide  = sel[0] || (sel == SEL_TOP);

    cc_opnd_fmt #(.DW(DW)) u_fmt (
        .wide (wide),
        .raw  ({op_r, op_b, op_a}),
        .sx   (opnd_sx),
        .zx   (opnd_zx),
        .neg  (opnd_neg),
        .nz   (opnd_nz)
    );

    cc_cmp_unit #(.DW(DW)) u_cmp (
        .sel  (sel_e),
        .a_sx (opnd_sx[OPND_A]),
        .b_sx (opnd_sx[OPND_B]),
        .a_zx (opnd_zx[OPND_A]),
        .b_zx (opnd_zx[OPND_B]),
        .r_sx (opnd_sx[OPND_R]),
        .cc   (cmp_cc)
    );

    cc_arith_unit #(.DW(DW)) u_ari (
        .sel  (sel_e),
        .wide (wide),
        .a    (opnd_zx[OPND_A]),
        .b    (opnd_zx[OPND_B]),
        .r    (opnd_zx[OPND_R]),
        .neg  (opnd_neg),
        .nz   (opnd_nz),
        .cc   (ari_cc)
    );

    cc_unary_unit #(.DW(DW)) u_una (
        .sel   (sel_e),
        .wide  (wide),
        .r     (opnd_zx[OPND_R]),
        .r_neg (opnd_neg[OPND_R]),
        .r_nz  (opnd_nz[OPND_R]),
        .cc    (una_cc)
    );

    // Group select
    always_comb begin
        err_nx = 1'b0;
        if (sel < GRP_CMP_LO)       cc_nx = sel[1:0];
        else if (sel < GRP_ARI_LO)  cc_nx = cmp_cc;
        else if (sel < GRP_UNA_LO)  cc_nx = ari_cc;
        else if (sel <= SEL_TOP)    cc_nx = una_cc;
        else begin
            cc_nx  = 2'd0;
            err_nx = 1'b1;
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                cc        <= 2'd0;
                sel_err   <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    cc      <= cc_nx;
                    sel_err <= err_nx;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign cc        = cc_nx;
        assign sel_err   = err_nx;
    end
endmodule

// File: rtl/cc_gen_check.sv
module cc_gen_check #(
    parameter bit REGD = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [4:0] sel,
    input logic       out_valid,
    input logic [1:0] cc,
    input logic       sel_err
);
    if (REGD) begin : g_props
        // R11
        vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid)
            else $error("out_valid missing after strobe");

        // R11
        vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid)
            else $error("out_valid without strobe");

        // R11
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(cc) && $stable(sel_err)))
            else $error("outputs moved without strobe");

        // R1
        const_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sel < 5'd4) |=> (cc == $past(sel[1:0]) && !sel_err))
            else $error("constant selector code wrong");

        // R10
        bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sel > 5'd28) |=> (sel_err && cc == 2'd0))
            else $error("unassigned selector not flagged");

        // R10
        good_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sel <= 5'd28) |=> !sel_err)
            else $error("error flag on assigned selector");

        // R8
        nabs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (sel == 5'd24 || sel == 5'd25)) |=> !cc[1])
            else $error("negative absolute code out of range");
    end
endmodule

bind cond_code_gen cc_gen_check #(.REGD(OUT_REG)) u_cc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sel       (sel),
    .out_valid (out_valid),
    .cc        (cc),
    .sel_err   (sel_err)
);

// File: tb/cond_code_gen_bench.sv
module cond_code_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    localparam logic [63:0] Z     = 64'h0;
    localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [4:0]  sel;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] r;
        logic [1:0]  cc;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VECS [NV] = '{
        // R1 constants
        '{5'd0,  Z, Z, Z, 2'd0, 1'b0, 4'd1},
        '{5'd1,  ONES, ONES, ONES, 2'd1, 1'b0, 4'd1},
        '{5'd2,  Z, Z, Z, 2'd2, 1'b0, 4'd1},
        '{5'd3,  Z, Z, Z, 2'd3, 1'b0, 4'd1},
        // R2 compares (R13 on the narrow unsigned one)
        '{5'd7,  ONES, 64'd1, Z, 2'd1, 1'b0, 4'd2},
        '{5'd9,  ONES, 64'd1, Z, 2'd2, 1'b0, 4'd2},
        '{5'd6,  64'd5, 64'd5, Z, 2'd0, 1'b0, 4'd2},
        '{5'd8,  64'h1_0000_0001, 64'd2, Z, 2'd1, 1'b0, 4'd13},
        '{5'd6,  64'h8000_0000, Z, Z, 2'd1, 1'b0, 4'd2},
        '{5'd9,  64'd3, 64'd3, Z, 2'd0, 1'b0, 4'd2},
        '{5'd7,  64'd1, ONES, Z, 2'd2, 1'b0, 4'd2},
        // R3 test against zero
        '{5'd5,  Z, Z, MIN64, 2'd1, 1'b0, 4'd3},
        '{5'd4,  Z, Z, 64'hFFFF_FFFF_0000_0005, 2'd2, 1'b0, 4'd3},
        '{5'd4,  ONES, ONES, Z, 2'd0, 1'b0, 4'd3},
        '{5'd5,  Z, Z, 64'd1, 2'd2, 1'b0, 4'd3},
        // R4 signed add / subtract
        '{5'd11, MAX64, 64'd1, MIN64, 2'd3, 1'b0, 4'd4},
        '{5'd11, 64'd5, 64'hFFFF_FFFF_FFFF_FFFB, Z, 2'd0, 1'b0, 4'd4},
        '{5'd10, 64'h8000_0000, 64'h8000_0000, Z, 2'd0, 1'b0, 4'd4},
        '{5'd10, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd3, 1'b0, 4'd4},
        '{5'd16, 64'd1, 64'h8000_0000, 64'h8000_0001, 2'd3, 1'b0, 4'd4},
        '{5'd17, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1, 1'b0, 4'd4},
        '{5'd17, 64'd9, 64'd4, 64'd5, 2'd2, 1'b0, 4'd4},
        // R5 logical add, with and without carry
        '{5'd13, ONES, 64'd1, Z, 2'd2, 1'b0, 4'd5},
        '{5'd13, 64'd1, 64'd2, 64'd3, 2'd1, 1'b0, 4'd5},
        '{5'd12, 64'hFFFF_FFFF, 64'd2, 64'hABCD_0000_0000_0001, 2'd3, 1'b0, 4'd5},
        '{5'd15, ONES, Z, Z, 2'd2, 1'b0, 4'd5},
        '{5'd14, 64'd1, 64'd2, 64'd4, 2'd1, 1'b0, 4'd5},
        '{5'd14, Z, 64'hFFFF_FFFF, Z, 2'd2, 1'b0, 4'd5},
        '{5'd15, 64'd2, 64'd3, 64'd5, 2'd1, 1'b0, 4'd5},
        // R6 logical subtract
        '{5'd19, 64'd5, 64'd5, Z, 2'd2, 1'b0, 4'd6},
        '{5'd19, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1, 1'b0, 4'd6},
        '{5'd19, 64'd5, 64'd3, 64'd2, 2'd3, 1'b0, 4'd6},
        '{5'd18, 64'h1_0000_0003, 64'd5, 64'hFFFF_FFFE, 2'd1, 1'b0, 4'd6},
        // R7 subtract with borrow
        '{5'd21, 64'd5, 64'd5, Z, 2'd2, 1'b0, 4'd7},
        '{5'd21, 64'd5, 64'd5, ONES, 2'd1, 1'b0, 4'd7},
        '{5'd20, Z, Z, 64'hFFFF_FFFF, 2'd1, 1'b0, 4'd7},
        '{5'd20, 64'd7, 64'd2, 64'd4, 2'd3, 1'b0, 4'd7},
        '{5'd21, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1, 1'b0, 4'd7},
        // R8 absolute, negative absolute, complement (R13 on a narrow one)
        '{5'd23, Z, Z, MIN64, 2'd3, 1'b0, 4'd8},
        '{5'd23, Z, Z, 64'd5, 2'd2, 1'b0, 4'd8},
        '{5'd22, Z, Z, 64'hFFFF_FFFF_8000_0000, 2'd3, 1'b0, 4'd8},
        '{5'd22, Z, Z, 64'h1_0000_0000, 2'd0, 1'b0, 4'd13},
        '{5'd23, Z, Z, ONES, 2'd2, 1'b0, 4'd8},
        '{5'd25, Z, Z, Z, 2'd0, 1'b0, 4'd8},
        '{5'd24, Z, Z, 64'hFFFF_FFFF, 2'd1, 1'b0, 4'd8},
        '{5'd27, Z, Z, 64'hFFFF_FFFF_FFFF_FFFD, 2'd1, 1'b0, 4'd8},
        '{5'd26, Z, Z, 64'h8000_0000, 2'd3, 1'b0, 4'd8},
        '{5'd26, Z, Z, 64'd7, 2'd2, 1'b0, 4'd8},
        '{5'd27, Z, Z, Z, 2'd0, 1'b0, 4'd8},
        // R9 nonzero test over the full width
        '{5'd28, Z, Z, 64'h1_0000_0000, 2'd1, 1'b0, 4'd9},
        '{5'd28, ONES, ONES, Z, 2'd0, 1'b0, 4'd9},
        // R10 unassigned selectors, then an assigned one clears the flag
        '{5'd29, ONES, ONES, ONES, 2'd0, 1'b1, 4'd10},
        '{5'd30, Z, Z, Z, 2'd0, 1'b1, 4'd10},
        '{5'd31, 64'd5, 64'd5, 64'd5, 2'd0, 1'b1, 4'd10},
        '{5'd2,  Z, Z, Z, 2'd2, 1'b0, 4'd10},
        '{5'd13, 64'd1, 64'd2, 64'd3, 2'd1, 1'b0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  sel = '0;
    logic [63:0] op_a = '0, op_b = '0, op_r = '0;
    logic        out_valid;
    logic [1:0]  cc;
    logic        sel_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_code_gen u_cond_code_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sel       (sel),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_r      (op_r),
        .out_valid (out_valid),
        .cc        (cc),
        .sel_err   (sel_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Strobe one cycle; return at the falling edge after the capturing edge
    task automatic drive(input logic [4:0] s, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] r);
        @(negedge clk);
        in_valid = 1'b1; sel = s; op_a = a; op_b = b; op_r = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 cc in reset", 64'(cc), 64'd0);
        check("R12 sel_err in reset", 64'(sel_err), 64'd0);
        check("R12 out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].sel, VECS[i].a, VECS[i].b, VECS[i].r);
            check($sformatf("R%0d vec %0d cc", VECS[i].req, i), 64'(cc), 64'(VECS[i].cc));
            check($sformatf("R%0d vec %0d sel_err", VECS[i].req, i), 64'(sel_err), 64'(VECS[i].err));
            check($sformatf("R11 vec %0d out_valid", i), 64'(out_valid), 64'd1);
        end

        // R11 hold: inputs change with no strobe
        @(negedge clk);
        sel = 5'd3; op_a = ONES; op_b = Z; op_r = MIN64;
        check("R11 out_valid drops", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R11 cc holds without strobe", 64'(cc), 64'd1);
        check("R11 out_valid stays low", 64'(out_valid), 64'd0);

        // R11 back-to-back strobes, each result in its own cycle
        @(negedge clk);
        in_valid = 1'b1; sel = 5'd31;
        @(negedge clk);
        sel = 5'd23; op_r = MIN64;
        check("R10 back-to-back first err", 64'(sel_err), 64'd1);
        check("R11 back-to-back first valid", 64'(out_valid), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 back-to-back second cc", 64'(cc), 64'd3);
        check("R10 back-to-back second err", 64'(sel_err), 64'd0);
        check("R11 back-to-back second valid", 64'(out_valid), 64'd1);

        // R12 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 cc after mid reset", 64'(cc), 64'd0);
        check("R12 out_valid after mid reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        drive(5'd16, 64'd1, 64'h8000_0000, 64'h8000_0001);
        check("R4 after reset release", 64'(cc), 64'd3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule